// File: doc/BRIEF.md
# Transceiver Operating Mode Sequencer

This block turns a 3-bit operating-mode code, held in the configuration register at address 0, into one enable line for each transceiver subsystem. These are the crystal oscillator, the synthesizer group (PLL, VCO and LO generation), the receive chain, the low-noise amplifier, the transmit chain, the transmit lowpass bypass, the amplitude detector, the receive output buffers and the two loopback paths. Configuration arrives as single-cycle register-write strobes that carry an address and a data word. Bit 0 of address 0 selects whether later writes to other addresses reach the main bank or the local bank.

The block also times two events. The first is the external power-amplifier bias. It follows the transmit chain on after a programmable number of ticks and drops in the same cycle that transmit mode is left. The second is synthesizer band acquisition. It starts when the main-bank addresses 15, 16 and 17 are written in that order. It then runs for a fixed number of ticks and ends with a locked flag. Both timers count pulses of an input tick strobe, so the real-time scale is set by the tick rate: 1 µs ticks with the default count give a 2 ms acquisition.

Top module: `xcvr_mode_seq`

## Requirements
- R1: After reset the mode is 000, only `osc_en` is high, and `pa_bias`, `acquiring` and `locked` are low.
- R2: A write to address 0 loads the mode from data bits 4:2 and the bank select from data bit 0, effective at that clock edge. Writes to any other address never change the mode.
- R3: Mode 000 (clock output) and the unused code 111 drive `osc_en` high and every other enable low.
- R4: Mode 001 (standby) drives `osc_en` and `synth_en` high and all other enables low.
- R5: Mode 010 (receive) drives `osc_en`, `synth_en`, `rx_en`, `lna_en` and `rxbuf_en` high and the rest low.
- R6: Mode 011 (transmit) drives `osc_en`, `synth_en` and `tx_en` high and the rest low.
- R7: Mode 100 (transmit calibration) drives `osc_en`, `synth_en`, `tx_en`, `det_en` and `rxbuf_en` high and the rest low.
- R8: Mode 101 (RF loopback) drives `osc_en`, `synth_en`, `tx_en`, `rx_en`, `rxbuf_en`, `lb_rf_en` and `lpf_byp` high, and keeps `lna_en` and the rest low.
- R9: Mode 110 (baseband loopback) drives `osc_en`, `synth_en`, `tx_en`, `rx_en`, `rxbuf_en` and `lb_bb_en` high and the rest low.
- R10: In mode 011, `pa_bias` rises once `pa_dly` tick pulses have been seen since transmit entry; with `pa_dly` = 0 it rises together with `tx_en`. In any other mode it stays low.
- R11: `pa_bias` falls in the same cycle that the mode leaves 011, and the delay count restarts on the next entry.
- R12: Main-bank writes to 15, then 16, then 17 start acquisition. A write to 16 or 17 out of order clears the tracker. A write to 15 always restarts it. Other addresses, and all writes while the bank select is 1, leave the tracker unchanged.
- R13: Starting acquisition sets `acquiring` and clears `locked`. After ACQ_TICKS tick pulses, `acquiring` falls and `locked` rises in the same cycle. A new start restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register-write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 10 | Register write data |
| tick | input | 1 | Timebase pulse for both timers |
| pa_dly | input | 8 | Amplifier bias delay in ticks |
| osc_en | output | 1 | Oscillator enable |
| synth_en | output | 1 | Synthesizer/VCO/LO enable |
| rx_en | output | 1 | Receive chain enable |
| lna_en | output | 1 | Low-noise amplifier enable |
| tx_en | output | 1 | Transmit chain enable |
| lpf_byp | output | 1 | Transmit lowpass bypass |
| det_en | output | 1 | Amplitude detector enable |
| rxbuf_en | output | 1 | Receive output buffer enable |
| lb_rf_en | output | 1 | RF loopback path enable |
| lb_bb_en | output | 1 | Baseband loopback path enable |
| pa_bias | output | 1 | External amplifier bias |
| acquiring | output | 1 | Band acquisition running |
| locked | output | 1 | Acquisition completed |

## Verification
The bench attacks the write-order tracker with a repeated 15, a doubled 16, a skipped 16 and a sequence written with the local bank selected. A tracker that does not restart on 15 would miss a legal start, and one that ignores the bank bit would start falsely. It steps the bias delay to one tick before and at the programmed count, uses a zero delay, and leaves transmit in the cycle under test, where an off-by-one counter or a registered bias would show the wrong edge. It runs acquisition to ACQ_TICKS−1 and to ACQ_TICKS ticks and restarts it from the locked state. Random writes, some to non-zero addresses carrying mode-like bit patterns, expose a mode register that decodes the wrong bits or the wrong address.

// File: rtl/xcvr_mode_pkg.sv
// Shared types for the mode sequencer: mode codes and the enable bundle.
// Assumes the mode field is three bits wide.
package xcvr_mode_pkg;
    typedef enum logic [2:0] {
        MD_CLKOUT = 3'd0,
        MD_STBY   = 3'd1,
        MD_RX     = 3'd2,
        MD_TX     = 3'd3,
        MD_TXCAL  = 3'd4,
        MD_RFLB   = 3'd5,
        MD_BBLB   = 3'd6,
        MD_SPARE  = 3'd7
    } mode_e;

    typedef struct packed {
        logic osc;
        logic synth;
        logic rx;
        logic lna;
        logic tx;
        logic lpf_byp;
        logic det;
        logic rxbuf;
        logic lb_rf;
        logic lb_bb;
    } en_s;
endpackage

// File: rtl/xms_cfg_regs.sv
// Holds register 0: the mode code and the bank select. It flags writes that
// reach the main bank at a non-zero address. Assumes address 0 is always
// reachable, whatever the bank select.
module xms_cfg_regs
    import xcvr_mode_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 10,
    parameter int MODE_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mode_e             mode,
    output logic              main_wr
);
    logic  bank_q;
    mode_e mode_q;
    logic  is_reg0;

    assign is_reg0 = (wr_addr == '0);

    // Load mode and bank select on a write to address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_CLKOUT;
            bank_q <= 1'b0;
        end else if (wr_en && is_reg0) begin
            mode_q <= mode_e'(wr_data[MODE_LSB +: 3]);
            bank_q <= wr_data[0];
        end
    end

    // A main-bank write to any register except 0.
    assign main_wr = wr_en && !is_reg0 && !bank_q;
    assign mode    = mode_q;
endmodule

// File: rtl/xms_decode.sv
// Maps the mode code to the per-subsystem enable bundle. Purely combinational.
// Undefined codes fall back to oscillator only.
module xms_decode
    import xcvr_mode_pkg::*;
(
    input  mode_e mode,
    output en_s   en
);
    // One enable set per mode code.
    always_comb begin
        en     = '0;
        en.osc = 1'b1;
        case (mode)
            MD_STBY:  en.synth = 1'b1;
            MD_RX: begin
                en.synth = 1'b1; en.rx = 1'b1; en.lna = 1'b1; en.rxbuf = 1'b1;
            end
            MD_TX: begin
                en.synth = 1'b1; en.tx = 1'b1;
            end
            MD_TXCAL: begin
                en.synth = 1'b1; en.tx = 1'b1; en.det = 1'b1; en.rxbuf = 1'b1;
            end
            MD_RFLB: begin
                en.synth = 1'b1; en.tx = 1'b1; en.rx = 1'b1; en.rxbuf = 1'b1;
                en.lb_rf = 1'b1; en.lpf_byp = 1'b1;
            end
            MD_BBLB: begin
                en.synth = 1'b1; en.tx = 1'b1; en.rx = 1'b1; en.rxbuf = 1'b1;
                en.lb_bb = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xms_pa_delay.sv
// Delays the amplifier bias behind transmit entry by dly tick pulses.
// Assumes dly is held steady while in transmit; the bias follows tx_on down
// without a register stage.
module xms_pa_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_on,
    input  logic             tick,
    input  logic [DLY_W-1:0] dly,
    output logic             bias
);
    logic [DLY_W-1:0] cnt_q;

    // Count ticks while in transmit, saturating at dly; clear outside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_on)
            cnt_q <= '0;
        else if (tick && (cnt_q < dly))
            cnt_q <= cnt_q + 1'b1;
    end

    assign bias = tx_on && (cnt_q >= dly);
endmodule

// File: rtl/xms_acq.sv
// Tracks the ordered write sequence A_FIRST, A_MID, A_LAST on the main bank.
// Completing it runs a band-acquisition timer of ACQ_TICKS ticks that ends in lock.
module xms_acq #(
    parameter int ADDR_W    = 5,
    parameter int ACQ_TICKS = 2000,
    parameter int A_FIRST   = 15,
    parameter int A_MID     = 16,
    parameter int A_LAST    = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              tick,
    output logic              acquiring,
    output logic              locked
);
    localparam int CNT_W = $clog2(ACQ_TICKS + 1);
    localparam logic [ADDR_W-1:0] AF = ADDR_W'(A_FIRST);
    localparam logic [ADDR_W-1:0] AM = ADDR_W'(A_MID);
    localparam logic [ADDR_W-1:0] AL = ADDR_W'(A_LAST);
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(ACQ_TICKS - 1);

    typedef enum logic [1:0] {SQ_IDLE, SQ_GOT1, SQ_GOT2} seq_e;

    seq_e             seq_q;
    logic [CNT_W-1:0] cnt_q;
    logic             acq_q, lock_q;
    logic             start;

    assign start = main_wr && (wr_addr == AL) && (seq_q == SQ_GOT2);

    // Ordering tracker: the first address restarts it, out-of-order writes clear it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_q <= SQ_IDLE;
        else if (main_wr) begin
            if (wr_addr == AF)
                seq_q <= SQ_GOT1;
            else if (wr_addr == AM)
                seq_q <= (seq_q == SQ_GOT1) ? SQ_GOT2 : SQ_IDLE;
            else if (wr_addr == AL)
                seq_q <= SQ_IDLE;
        end
    end

    // Acquisition timer: restart on start, lock after ACQ_TICKS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_q  <= 1'b0;
            lock_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            acq_q  <= 1'b1;
            lock_q <= 1'b0;
            cnt_q  <= '0;
        end else if (acq_q && tick) begin
            if (cnt_q == LAST_CNT) begin
                acq_q  <= 1'b0;
                lock_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign acquiring = acq_q;
    assign locked    = lock_q;
endmodule

// File: rtl/xcvr_mode_seq.sv
// Top of the mode sequencer: register 0, the mode decode, the amplifier bias
// delay and the acquisition timer. Assumes single-cycle write strobes and a
// tick strobe one cycle wide.
module xcvr_mode_seq
    import xcvr_mode_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 10,
    parameter int DLY_W     = 8,
    parameter int ACQ_TICKS = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    input  logic [DLY_W-1:0]  pa_dly,
    output logic              osc_en,
    output logic              synth_en,
    output logic              rx_en,
    output logic              lna_en,
    output logic              tx_en,
    output logic              lpf_byp,
    output logic              det_en,
    output logic              rxbuf_en,
    output logic              lb_rf_en,
    output logic              lb_bb_en,
    output logic              pa_bias,
    output logic              acquiring,
    output logic              locked
);
    mode_e mode;
    logic  main_wr;
    en_s   en;

    xms_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_LSB(2)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .main_wr(main_wr)
    );

    xms_decode u_dec (.mode(mode), .en(en));

    xms_pa_delay #(.DLY_W(DLY_W)) u_pa (
        .clk(clk), .rst_n(rst_n), .tx_on(mode == MD_TX), .tick(tick),
        .dly(pa_dly), .bias(pa_bias)
    );

    xms_acq #(.ADDR_W(ADDR_W), .ACQ_TICKS(ACQ_TICKS)) u_acq (
        .clk(clk), .rst_n(rst_n), .main_wr(main_wr), .wr_addr(wr_addr),
        .tick(tick), .acquiring(acquiring), .locked(locked)
    );

    assign osc_en   = en.osc;
    assign synth_en = en.synth;
    assign rx_en    = en.rx;
    assign lna_en   = en.lna;
    assign tx_en    = en.tx;
    assign lpf_byp  = en.lpf_byp;
    assign det_en   = en.det;
    assign rxbuf_en = en.rxbuf;
    assign lb_rf_en = en.lb_rf;
    assign lb_bb_en = en.lb_bb;
endmodule

// File: rtl/xms_chk.sv
// Property checker for the mode sequencer, bound to every instance of the top.
module xms_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [4:0] wr_addr,
    input logic       osc_en,
    input logic       rx_en,
    input logic       lna_en,
    input logic       tx_en,
    input logic       det_en,
    input logic       rxbuf_en,
    input logic       lb_rf_en,
    input logic       pa_bias,
    input logic       acquiring,
    input logic       locked
);
    // R3
    osc_on_chk: assert property (@(posedge clk) disable iff (!rst_n) osc_en);
    // R10
    pa_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pa_bias |-> (tx_en && !det_en && !rxbuf_en));
    // R11
    pa_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> !pa_bias);
    // R8
    lna_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lna_en |-> (rx_en && !lb_rf_en));
    // R13
    lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acquiring && locked));
    // R13
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(acquiring));
    // R12
    acq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acquiring) |-> ($past(wr_en) && $past(wr_addr) == 5'd17));
endmodule

bind xcvr_mode_seq xms_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .osc_en(osc_en), .rx_en(rx_en), .lna_en(lna_en), .tx_en(tx_en),
    .det_en(det_en), .rxbuf_en(rxbuf_en), .lb_rf_en(lb_rf_en),
    .pa_bias(pa_bias), .acquiring(acquiring), .locked(locked)
);

// File: tb/sim_xcvr_mode_seq.sv
// Bench for the mode sequencer: seeded random writes against a bench model,
// then directed corner cases for the bias delay and acquisition.
module sim_xcvr_mode_seq;
    localparam int ACQ = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic       tick = 1'b0;
    logic [7:0] pa_dly = '0;
    logic osc_en, synth_en, rx_en, lna_en, tx_en, lpf_byp, det_en, rxbuf_en;
    logic lb_rf_en, lb_bb_en, pa_bias, acquiring, locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xcvr_mode_seq #(.ACQ_TICKS(ACQ)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .pa_dly(pa_dly),
        .osc_en(osc_en), .synth_en(synth_en), .rx_en(rx_en), .lna_en(lna_en),
        .tx_en(tx_en), .lpf_byp(lpf_byp), .det_en(det_en), .rxbuf_en(rxbuf_en),
        .lb_rf_en(lb_rf_en), .lb_bb_en(lb_bb_en), .pa_bias(pa_bias),
        .acquiring(acquiring), .locked(locked)
    );

    // Expected enables {osc,synth,rx,lna,tx,byp,det,rxbuf,lb_rf,lb_bb}.
    function automatic logic [9:0] exp_en(input logic [2:0] c);
        case (c)
            3'd1:    return 10'b1100000000;
            3'd2:    return 10'b1111000100;
            3'd3:    return 10'b1100100000;
            3'd4:    return 10'b1100101100;
            3'd5:    return 10'b1110110110;
            3'd6:    return 10'b1110100101;
            default: return 10'b1000000000;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [9:0] act_en();
        return {osc_en, synth_en, rx_en, lna_en, tx_en, lpf_byp, det_en,
                rxbuf_en, lb_rf_en, lb_bb_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [9:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [9:0] mdat(input logic [2:0] c, input logic bank);
        return {5'b0, c, 1'b0, bank};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [2:0] mode_m;
        logic       bank_m, acq_m, lock_m;
        int         seq_m;
        void'($urandom(32'd20240611));

        do_reset();
        // R1: reset state
        chk("R1 enables", 32'(act_en()), 32'(10'b1000000000));
        chk("R1 flags", {29'd0, pa_bias, acquiring, locked}, 32'd0);

        // Random phase, ticks held low; model is the requirement list.
        mode_m = 3'd0; bank_m = 1'b0; acq_m = 1'b0; lock_m = 1'b0; seq_m = 0;
        pa_dly = 8'd0;
        for (int i = 0; i < 400; i++) begin
            int         k;
            logic [4:0] a;
            logic [9:0] d;
            k = int'($urandom % 7);
            d = 10'($urandom);
            if (k <= 1) a = 5'd0;
            else if (k == 2) a = 5'd15;
            else if (k == 3) a = 5'd16;
            else if (k == 4) a = 5'd17;
            else a = 5'd1 + 5'($urandom % 14);
            if (a == 5'd0 && ($urandom % 4) != 0) d[0] = 1'b0;
            wr(a, d);
            if (a == 5'd0) begin
                mode_m = d[4:2];
                bank_m = d[0];
            end else if (!bank_m) begin
                if (a == 5'd15) seq_m = 1;
                else if (a == 5'd16) seq_m = (seq_m == 1) ? 2 : 0;
                else if (a == 5'd17) begin
                    if (seq_m == 2) begin acq_m = 1'b1; lock_m = 1'b0; end
                    seq_m = 0;
                end
            end
            // R2 with R3..R9: mode from bits 4:2 of address 0 only
            chk(req_of(mode_m), 32'(act_en()), 32'(exp_en(mode_m)));
            // R12: ordered start
            chk("R12 acquiring", 32'(acquiring), 32'(acq_m));
            // R10: zero delay gives bias with tx
            chk("R10 bias", 32'(pa_bias), 32'(mode_m == 3'd3));
        end

        // Directed phase.
        do_reset();
        for (int c = 0; c < 8; c++) begin
            wr(5'd0, mdat(3'(c), 1'b0));
            chk(req_of(3'(c)), 32'(act_en()), 32'(exp_en(3'(c))));
        end
        // R2: non-zero address carrying a mode pattern leaves mode alone
        wr(5'd0, mdat(3'd1, 1'b0));
        wr(5'd9, 10'b0000001100);
        chk("R2 other address", 32'(act_en()), 32'(exp_en(3'd1)));

        // R10: delay of 5 ticks
        pa_dly = 8'd5;
        wr(5'd0, mdat(3'd3, 1'b0));
        chk("R10 bias at entry", 32'(pa_bias), 32'd0);
        ticks(4);
        chk("R10 bias after 4", 32'(pa_bias), 32'd0);
        ticks(1);
        chk("R10 bias after 5", 32'(pa_bias), 32'd1);
        // R11: leave tx, bias drops in the same cycle
        wr(5'd0, mdat(3'd1, 1'b0));
        chk("R11 bias off", 32'(pa_bias), 32'd0);
        chk("R11 tx off", 32'(tx_en), 32'd0);
        wr(5'd0, mdat(3'd3, 1'b0));
        ticks(4);
        chk("R11 count restarted", 32'(pa_bias), 32'd0);
        // R10: other tx-like modes never bias
        wr(5'd0, mdat(3'd4, 1'b0));
        ticks(8);
        chk("R10 txcal no bias", 32'(pa_bias), 32'd0);
        // R10: zero delay
        pa_dly = 8'd0;
        wr(5'd0, mdat(3'd3, 1'b0));
        chk("R10 zero delay", 32'(pa_bias), 32'd1);

        // R12: local bank writes ignored
        wr(5'd0, mdat(3'd1, 1'b1));
        wr(5'd15, '0); wr(5'd16, '0); wr(5'd17, '0);
        chk("R12 local bank", 32'(acquiring), 32'd0);
        wr(5'd0, mdat(3'd1, 1'b0));
        // R12: skipped 16
        wr(5'd15, '0); wr(5'd17, '0);
        chk("R12 skipped", 32'(acquiring), 32'd0);
        // R12: doubled 16
        wr(5'd15, '0); wr(5'd16, '0); wr(5'd16, '0); wr(5'd17, '0);
        chk("R12 doubled", 32'(acquiring), 32'd0);
        // R12: repeated 15 restarts, other address in between is ignored
        wr(5'd15, '0); wr(5'd15, '0); wr(5'd16, '0); wr(5'd3, '0); wr(5'd17, '0);
        chk("R12 restart start", 32'(acquiring), 32'd1);
        chk("R13 not locked yet", 32'(locked), 32'd0);

        // R13: timer length
        ticks(ACQ - 1);
        chk("R13 still acquiring", 32'(acquiring), 32'd1);
        chk("R13 not locked", 32'(locked), 32'd0);
        ticks(1);
        chk("R13 acq done", 32'(acquiring), 32'd0);
        chk("R13 locked", 32'(locked), 32'd1);
        // R13: restart clears lock
        wr(5'd15, '0); wr(5'd16, '0); wr(5'd17, '0);
        chk("R13 restart clears lock", {30'd0, acquiring, locked}, 32'd2);
        ticks(10);
        wr(5'd15, '0); wr(5'd16, '0); wr(5'd17, '0);
        ticks(ACQ - 1);
        chk("R13 restart resets count", 32'(locked), 32'd0);
        ticks(1);
        chk("R13 relocked", 32'(locked), 32'd1);

        finish_run();
    end
endmodule